// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt requests and presents the single most urgent one to a processor. The request is given as an interrupt level and a vector number. Each source has four pieces of state: a pending bit that tracks its request line, a mask bit, a software force bit, and a programmable priority byte. A priority byte of zero disables the source.

On every cycle a balanced comparison tree picks the winner among the active sources. The highest priority byte wins. When two sources have equal bytes, the one with the higher source number wins. The winner's level and vector are registered onto the outputs. Software reaches the block through a small synchronous register bus with an 8-bit offset. Through that bus it can program priorities, load the mask by halves, set or clear single mask bits or the whole mask with one byte write, load force bits, and read the current vector back as a software acknowledge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, all pending bits, force bits and priority bytes are 0, `irq_level` is 0 and `irq_vector` is 24.
- R2: Pending bit i is `irq_req[i]` registered once. Offset 0x04 reads pending bits 31:0 and offset 0x00 reads bits 63:32. Writes to either offset have no effect.
- R3: Offset 0x0C (bits 31:0) and offset 0x08 (bits 63:32) read and write the mask. They accept word-size writes only (`bus_byte`=0). A mask bit of 1 blocks its source.
- R4: Offset 0x14 (bits 31:0) and offset 0x10 (bits 63:32) read and write the force bits with word-size writes. A forced source counts as requesting even while its request line is low.
- R5: Offset 0x40+n holds the priority byte of source n, written from `bus_wdata[7:0]` with either size and read back in bits 7:0. A zero byte disables source n.
- R6: A source is active when it is (pending or forced), unmasked and has a nonzero priority byte. The active source with the largest byte wins, `irq_level` shows that byte and `irq_vector` shows 64 plus the source number.
- R7: Among active sources with equal priority bytes, the higher-numbered source wins.
- R8: With no active source, `irq_level` is 0 and `irq_vector` is 24.
- R9: A byte-size write to 0x1C sets mask bit `bus_wdata[5:0]`. When `bus_wdata[6]` is 1 it sets every mask bit instead.
- R10: A byte-size write to 0x1D clears mask bit `bus_wdata[5:0]`. When `bus_wdata[6]` is 1 it clears every mask bit instead.
- R11: A read of 0xE0 returns the current `irq_vector`. Reads of 0xE1 to 0xE7 and of unmapped offsets return 0, and writes to unmapped offsets change nothing.
- R12: `irq_level` and `irq_vector` change on the clock edge after the edge that updated the registers. `bus_rdata` is loaded on an edge where `bus_re` is 1 and holds its value otherwise.
- R13: Word-size writes to 0x1C or 0x1D and byte-size writes to the mask halves have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_byte | input | 1 | 1 = byte-size access, 0 = word-size access |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_level | output | 8 | Priority byte of the winning source, 0 when idle |
| irq_vector | output | 8 | 64 + winning source, or 24 when idle |

## Verification
The embedded assertions check four things on every cycle: that pending bits track the registered request lines, that the all-bits set and clear shortcuts take effect on the next edge, that a zero priority write leaves that source's byte at zero, and that the idle and busy vector ranges match the output level. Arbitration order cannot be judged locally, so the directed scenarios cover it. They check the largest-byte winner, the higher-number tie rule, force-driven requests, disabling by zero priority, and mask blocking. The scenarios also cover ignored writes, size-qualified shortcuts, the acknowledge read, and the one-cycle output lag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC     = 64;
    localparam int IDX_W    = $clog2(NSRC);
    localparam int LVL_W    = 8;
    localparam int DATA_W   = 32;
    localparam int OFS_W    = 8;
    localparam int VEC_W    = 8;
    localparam int HALF     = NSRC / 2;

    localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;
    localparam logic [VEC_W-1:0] VEC_IDLE = 8'd24;

    localparam logic [OFS_W-1:0] OFS_PEND_HI = 8'h00;
    localparam logic [OFS_W-1:0] OFS_PEND_LO = 8'h04;
    localparam logic [OFS_W-1:0] OFS_MASK_HI = 8'h08;
    localparam logic [OFS_W-1:0] OFS_MASK_LO = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_FRC_HI  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_FRC_LO  = 8'h14;
    localparam logic [OFS_W-1:0] OFS_MSET    = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 8'h1D;
    localparam logic [OFS_W-1:0] OFS_SWACK   = 8'hE0;
    localparam logic [1:0]       LVL_WIN_TAG = 2'b01;   // 0x40..0x7F

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] idx;
    } cand_t;

    typedef enum logic [1:0] {
        MOP_NONE,
        MOP_SET,
        MOP_CLR
    } mask_op_e;

    // lo covers lower source numbers; hi wins on equal level
    function automatic cand_t cand_pick(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || hi.lvl >= lo.lvl))
            return hi;
        return lo;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   req,
    input  logic [OFS_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              is_byte,
    input  logic              re,
    input  logic [VEC_W-1:0]  ack_vec,
    output logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   force_q,
    output logic [LVL_W-1:0]  lvl_q [NSRC],
    output logic [DATA_W-1:0] rdata_q
);
    logic     wr_word;
    logic     wr_lvl;
    mask_op_e mop;
    logic     mop_all;
    logic [IDX_W-1:0] mop_idx;
    logic [DATA_W-1:0] rd_mux;

    assign wr_word = we && !is_byte;
    assign wr_lvl  = we && (addr[OFS_W-1:IDX_W] == LVL_WIN_TAG);
    assign mop_all = wdata[IDX_W];
    assign mop_idx = wdata[IDX_W-1:0];

    always_comb begin
        mop = MOP_NONE;
        if (we && is_byte && addr == OFS_MSET) mop = MOP_SET;
        if (we && is_byte && addr == OFS_MCLR) mop = MOP_CLR;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else begin
            if (wr_word && addr == OFS_MASK_HI) mask_q[NSRC-1:HALF] <= wdata;
            if (wr_word && addr == OFS_MASK_LO) mask_q[HALF-1:0]    <= wdata;
            case (mop)
                MOP_SET: begin
                    if (mop_all) mask_q <= '1;
                    else         mask_q[mop_idx] <= 1'b1;
                end
                MOP_CLR: begin
                    if (mop_all) mask_q <= '0;
                    else         mask_q[mop_idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= '0;
        end else begin
            if (wr_word && addr == OFS_FRC_HI) force_q[NSRC-1:HALF] <= wdata;
            if (wr_word && addr == OFS_FRC_LO) force_q[HALF-1:0]    <= wdata;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[i] <= '0;
            else if (wr_lvl && addr[IDX_W-1:0] == IDX_W'(i))
                lvl_q[i] <= wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr[OFS_W-1:IDX_W] == LVL_WIN_TAG) begin
            rd_mux = DATA_W'(lvl_q[addr[IDX_W-1:0]]);
        end else begin
            case (addr)
                OFS_PEND_HI: rd_mux = pend_q[NSRC-1:HALF];
                OFS_PEND_LO: rd_mux = pend_q[HALF-1:0];
                OFS_MASK_HI: rd_mux = mask_q[NSRC-1:HALF];
                OFS_MASK_LO: rd_mux = mask_q[HALF-1:0];
                OFS_FRC_HI:  rd_mux = force_q[NSRC-1:HALF];
                OFS_FRC_LO:  rd_mux = force_q[HALF-1:0];
                OFS_SWACK:   rd_mux = DATA_W'(ack_vec);
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (re) rdata_q <= rd_mux;
    end

    // R2
    pend_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pend_q == $past(req));

    // R9
    mask_setall_chk: assert property (@(posedge clk) disable iff (rst)
        (we && is_byte && addr == OFS_MSET && wdata[IDX_W]) |=> (&mask_q));

    // R10
    mask_clrall_chk: assert property (@(posedge clk) disable iff (rst)
        (we && is_byte && addr == OFS_MCLR && wdata[IDX_W]) |=> (mask_q == '0));

    // R5
    lvl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lvl && wdata[LVL_W-1:0] == '0) |=> lvl_q[$past(addr[IDX_W-1:0])] == '0);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  mask,
    input  logic [NSRC-1:0]  frc,
    input  logic [LVL_W-1:0] lvl [NSRC],
    output cand_t            win
);
    cand_t leaf [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_leaf
        assign leaf[i].valid = (pend[i] | frc[i]) & ~mask[i] & (|lvl[i]);
        assign leaf[i].lvl   = lvl[i];
        assign leaf[i].idx   = IDX_W'(i);
    end

    // Balanced reduction: pairs (2j, 2j+1) merge into slot j each stage
    always_comb begin
        cand_t st [NSRC];
        for (int k = 0; k < NSRC; k++) st[k] = leaf[k];
        for (int w = NSRC / 2; w >= 1; w = w / 2) begin
            for (int j = 0; j < w; j++)
                st[j] = cand_pick(st[2*j], st[2*j+1]);
        end
        win = st[0];
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   irq_req,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_byte,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LVL_W-1:0]  irq_level,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [NSRC-1:0]  pend_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  force_q;
    logic [LVL_W-1:0] lvl_q [NSRC];
    cand_t            win;

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .is_byte (bus_byte),
        .re      (bus_re),
        .ack_vec (irq_vector),
        .pend_q  (pend_q),
        .mask_q  (mask_q),
        .force_q (force_q),
        .lvl_q   (lvl_q),
        .rdata_q (bus_rdata)
    );

    irqc_arb u_arb (
        .pend (pend_q),
        .mask (mask_q),
        .frc  (force_q),
        .lvl  (lvl_q),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_level  <= '0;
            irq_vector <= VEC_IDLE;
        end else if (win.valid) begin
            irq_level  <= win.lvl;
            irq_vector <= VEC_BASE + VEC_W'(win.idx);
        end else begin
            irq_level  <= '0;
            irq_vector <= VEC_IDLE;
        end
    end

    // R8
    idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_level == '0) |-> (irq_vector == VEC_IDLE));

    // R6
    busy_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (irq_vector >= VEC_BASE));

    // R6
    win_active_chk: assert property (@(posedge clk) disable iff (rst)
        win.valid |-> (!mask_q[win.idx] && (pend_q[win.idx] || force_q[win.idx])));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_req = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_byte = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [7:0]  irq_vector;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_byte(bus_byte), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic byt);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_byte = byt; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_out(string req, logic [7:0] lvl, logic [7:0] vec);
        check(req, {24'b0, irq_level}, {24'b0, lvl});
        check(req, {24'b0, irq_vector}, {24'b0, vec});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_out("R1", 8'd0, 8'd24);
        rd(8'h08, d); check("R1", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R1", d, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R1", d, 32'h0);
        rd(8'h45, d); check("R1", d, 32'h0);
        rd(8'hE0, d); check("R1", d, 32'd24);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        @(negedge clk);
        irq_req[5] = 1'b1; irq_req[40] = 1'b1;
        settle();
        rd(8'h04, d); check("R2", d, 32'h20);
        rd(8'h00, d); check("R2", d, 32'h100);
        wr(8'h04, 32'hFFFF_FFFF, 1'b0);
        rd(8'h04, d); check("R2", d, 32'h20);
        check_out("R8", 8'd0, 8'd24);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        wr(8'h45, 32'd3, 1'b1);
        wr(8'h68, 32'd7, 1'b1);
        rd(8'h68, d); check("R5", d, 32'd7);
        settle();
        check_out("R3", 8'd0, 8'd24);
        wr(8'h1D, 32'h40, 1'b1);
        check_out("R12", 8'd0, 8'd24);
        @(negedge clk);
        check_out("R12", 8'd7, 8'd104);
        rd(8'h08, d); check("R10", d, 32'h0);
        rd(8'h0C, d); check("R10", d, 32'h0);
    endtask

    task automatic t_arbitration();
        logic [31:0] d;
        wr(8'h45, 32'd7, 1'b1); settle();
        check_out("R7", 8'd7, 8'd104);
        wr(8'h10, 32'h1000_0000, 1'b0);
        rd(8'h10, d); check("R4", d, 32'h1000_0000);
        wr(8'h7C, 32'd7, 1'b1); settle();
        check_out("R4", 8'd7, 8'd124);
        wr(8'h45, 32'd9, 1'b1); settle();
        check_out("R6", 8'd9, 8'd69);
        wr(8'h45, 32'd7, 1'b1);
        wr(8'h7C, 32'd0, 1'b1); settle();
        rd(8'h7C, d); check("R5", d, 32'd0);
        check_out("R5", 8'd7, 8'd104);
        wr(8'h14, 32'h2, 1'b0); settle();
        rd(8'h14, d); check("R4", d, 32'h2);
        check_out("R4", 8'd7, 8'd104);
    endtask

    task automatic t_mask_words();
        logic [31:0] d;
        wr(8'h08, 32'h100, 1'b0); settle();
        rd(8'h08, d); check("R3", d, 32'h100);
        check_out("R3", 8'd7, 8'd69);
        wr(8'h0C, 32'h20, 1'b0); settle();
        check_out("R3", 8'd0, 8'd24);
    endtask

    task automatic t_shortcuts();
        logic [31:0] d;
        wr(8'h1D, 32'h40, 1'b1);
        wr(8'h1C, 32'd40, 1'b1); settle();
        rd(8'h08, d); check("R9", d, 32'h100);
        check_out("R9", 8'd7, 8'd69);
        wr(8'h1C, 32'h40, 1'b1); settle();
        rd(8'h0C, d); check("R9", d, 32'hFFFF_FFFF);
        check_out("R9", 8'd0, 8'd24);
        wr(8'h1D, 32'd5, 1'b1); settle();
        rd(8'h0C, d); check("R10", d, 32'hFFFF_FFDF);
        check_out("R10", 8'd7, 8'd69);
    endtask

    task automatic t_sizes();
        logic [31:0] d;
        wr(8'h1D, 32'h40, 1'b0);
        rd(8'h0C, d); check("R13", d, 32'hFFFF_FFDF);
        wr(8'h0C, 32'h0, 1'b1);
        rd(8'h0C, d); check("R13", d, 32'hFFFF_FFDF);
        wr(8'h1C, 32'd5, 1'b0); settle();
        check_out("R13", 8'd7, 8'd69);
    endtask

    task automatic t_ack_unmapped();
        logic [31:0] d;
        rd(8'hE0, d); check("R11", d, 32'd69);
        rd(8'hE3, d); check("R11", d, 32'h0);
        rd(8'h20, d); check("R11", d, 32'h0);
        wr(8'h20, 32'h0, 1'b0); settle();
        rd(8'h0C, d); check("R11", d, 32'hFFFF_FFDF);
        check_out("R11", 8'd7, 8'd69);
        @(negedge clk);
        bus_addr = 8'h04;
        repeat (2) @(negedge clk);
        check("R12", bus_rdata, 32'hFFFF_FFDF);
    endtask

    task automatic t_release();
        logic [31:0] d;
        @(negedge clk);
        irq_req[5] = 1'b0;
        settle();
        rd(8'h04, d); check("R2", d, 32'h0);
        check_out("R8", 8'd0, 8'd24);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pending();
        t_levels();
        t_arbitration();
        t_mask_words();
        t_shortcuts();
        t_sizes();
        t_ack_unmapped();
        t_release();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule